// File: doc/BRIEF.md
# Dual Byte-Addressed Hardware Stacks

This block holds the two stacks of a 16-bit stack machine whose datapath moves data over an 8-bit bus. One stack carries operands (the parameter stack) and the other carries return addresses (the return stack). Each stack is 256 words of 16 bits. Its storage is byte-wide, so every word is reached as two separate bytes: a low byte and a high byte.

Each stack has its own 8-bit pointer. The pointer counts up or down and wraps around at both ends. The datapath picks a stack and a byte, and can then read that byte of the word under the stack's pointer, or write it, or both. It also sends increment and decrement strobes to the chosen pointer. The storage address is formed from three parts. The stack select is the top bit, the pointer of the chosen stack is in the middle, and the byte select is the lowest bit. Both stacks therefore share one 1024-byte array.

A push is a sequence of micro-operations: an increment in one cycle, then byte writes to the new top in the cycles after it. A pop is the reverse: byte reads of the top, then a decrement. Reads are combinational from the current pointer. Writes and pointer changes take effect on the rising clock edge.

Top module: `dual_stack_unit`

## Requirements
- R1: While `rst_n` is low, both pointers are 0. The reset is asynchronous on assertion and is released on a clock edge.
- R2: When `inc_i` is high and `dec_i` is low, the pointer of the stack chosen by `stk_sel_i` (0 = parameter, 1 = return) rises by one at the clock edge. The other pointer does not change.
- R3: When `dec_i` is high and `inc_i` is low, the chosen pointer falls by one at the clock edge. The other pointer does not change.
- R4: Pointers wrap modulo 256: 255 plus one gives 0, and 0 minus one gives 255. No flag is raised.
- R5: When `inc_i` and `dec_i` are both high, or both low, neither pointer changes.
- R6: With `wr_en_i` high, `wr_data_i` is stored at the clock edge. It goes to byte address {`stk_sel_i`, pointer of the chosen stack, `byte_hi_i`}, where bit 0 = `byte_hi_i` (0 = low byte, 1 = high byte) and bit 9 = `stk_sel_i`. With `rd_en_i` high, `rd_data_o` shows that byte combinationally.
- R7: A write to one byte of a word leaves the other byte of the same word unchanged.
- R8: A write to one stack leaves the other stack unchanged, even where both pointers hold the same value.
- R9: `rd_data_o` is 0 while `rd_en_i` is low.
- R10: When a write and a pointer strobe fall in the same cycle, the write goes to the address given by the pointer value before that edge.
- R11: With `wr_en_i` low, no stored byte changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of both pointers |
| inc_i | input | 1 | Increment strobe for the chosen pointer |
| dec_i | input | 1 | Decrement strobe for the chosen pointer |
| stk_sel_i | input | 1 | Stack select: 0 = parameter, 1 = return |
| byte_hi_i | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_en_i | input | 1 | Drives the addressed byte onto rd_data_o |
| wr_en_i | input | 1 | Writes wr_data_i to the addressed byte |
| wr_data_i | input | 8 | Byte to be written |
| rd_data_o | output | 8 | Addressed byte, or 0 when not reading |
| pstk_ptr_o | output | 8 | Parameter stack pointer |
| rstk_ptr_o | output | 8 | Return stack pointer |

## Verification
The bench builds the block with its default parameters: 8-bit pointers and 8-bit bytes. This gives the full 256-entry range of each pointer, so wrapping in both directions is reached by walking a pointer past either end. The 1024-byte array is small enough that random traffic lands on the same word from both stacks and from both byte lanes. This exercises stack separation and byte independence at equal pointer values.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic {
    STK_PARAM  = 1'b0,
    STK_RETURN = 1'b1
  } stk_sel_e;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_UP   = 2'd1,
    PTR_DOWN = 2'd2
  } ptr_op_e;

  // Resolve the two strobes into one pointer action; both high cancels.
  function automatic ptr_op_e decode_ptr_op(input logic up, input logic down);
    ptr_op_e op;
    unique case ({up, down})
      2'b10:   op = PTR_UP;
      2'b01:   op = PTR_DOWN;
      default: op = PTR_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
  import stk_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] ptr_o
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_ce;
  ptr_op_e          op;

  // Next-state: modulo arithmetic gives the wrap for free.
  always_comb begin
    op     = decode_ptr_op(inc_i, dec_i);
    ptr_ce = 1'b0;
    ptr_d  = ptr_q;
    if (en_i) begin
      unique case (op)
        PTR_UP: begin
          ptr_ce = 1'b1;
          ptr_d  = ptr_q + PTR_W'(1);
        end
        PTR_DOWN: begin
          ptr_ce = 1'b1;
          ptr_d  = ptr_q - PTR_W'(1);
        end
        default: begin
          ptr_ce = 1'b0;
          ptr_d  = ptr_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
  parameter int PTR_W  = 8,
  parameter int N_STK  = 2,
  localparam int SEL_W  = (N_STK > 1) ? $clog2(N_STK) : 1,
  localparam int ADDR_W = SEL_W + PTR_W + 1
) (
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [N_STK-1:0][PTR_W-1:0] ptrs_i,
  input  logic                        byte_hi_i,
  output logic [ADDR_W-1:0]           addr_o
);

  logic [PTR_W-1:0] cur_ptr;

  always_comb begin
    cur_ptr = '0;
    for (int i = 0; i < N_STK; i++) begin
      if (sel_i == SEL_W'(i)) cur_ptr = ptrs_i[i];
    end
    // Stack select on top, word pointer in the middle, byte lane at bit 0.
    addr_o = {sel_i, cur_ptr, byte_hi_i};
  end

endmodule

// File: rtl/stk_byte_ram.sv
module stk_byte_ram #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);

  logic [BYTE_W-1:0] mem_q [DEPTH];

  // Storage carries no reset; only the write enable gates the update.
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit
  import stk_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              stk_sel_i,
  input  logic              byte_hi_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [PTR_W-1:0]  pstk_ptr_o,
  output logic [PTR_W-1:0]  rstk_ptr_o
);

  localparam int N_STK  = 2;
  localparam int SEL_W  = 1;
  localparam int ADDR_W = SEL_W + PTR_W + 1;

  logic [N_STK-1:0][PTR_W-1:0] ptrs;
  logic [ADDR_W-1:0]           addr;
  logic [BYTE_W-1:0]           ram_rdata;

  for (genvar g = 0; g < N_STK; g++) begin : g_ptr
    logic sel_me;
    assign sel_me = (stk_sel_i == SEL_W'(g));
    stk_ptr_ctrl #(
      .PTR_W(PTR_W)
    ) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (sel_me),
      .inc_i (inc_i),
      .dec_i (dec_i),
      .ptr_o (ptrs[g])
    );
  end

  stk_addr_gen #(
    .PTR_W(PTR_W),
    .N_STK(N_STK)
  ) i_addr (
    .sel_i     (stk_sel_i),
    .ptrs_i    (ptrs),
    .byte_hi_i (byte_hi_i),
    .addr_o    (addr)
  );

  stk_byte_ram #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
  ) i_ram (
    .clk     (clk),
    .we_i    (wr_en_i),
    .addr_i  (addr),
    .wdata_i (wr_data_i),
    .rdata_o (ram_rdata)
  );

  assign rd_data_o  = rd_en_i ? ram_rdata : '0;
  assign pstk_ptr_o = ptrs[STK_PARAM];
  assign rstk_ptr_o = ptrs[STK_RETURN];

endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int PTR_W  = 8,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inc_i,
  input logic              dec_i,
  input logic              stk_sel_i,
  input logic              byte_hi_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic [PTR_W-1:0]  pstk_ptr_o,
  input logic [PTR_W-1:0]  rstk_ptr_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_ZERO: assert (pstk_ptr_o == '0 && rstk_ptr_o == '0); // R1
    end
  end

  AST_PARAM_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !stk_sel_i) |=> (pstk_ptr_o == PTR_W'($past(pstk_ptr_o) + 1'b1))); // R2

  AST_RET_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && stk_sel_i) |=> (rstk_ptr_o == PTR_W'($past(rstk_ptr_o) + 1'b1))); // R2

  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_sel_i) |=> $stable(rstk_ptr_o)); // R2

  AST_PARAM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !stk_sel_i) |=> (pstk_ptr_o == PTR_W'($past(pstk_ptr_o) - 1'b1))); // R3

  AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == dec_i) |=> ($stable(pstk_ptr_o) && $stable(rstk_ptr_o))); // R5

  AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (inc_i == dec_i)) ##1 (rd_en_i && $stable(stk_sel_i) && $stable(byte_hi_i))
      |-> (rd_data_o == $past(wr_data_i))); // R6

  always_comb begin
    if (!rd_en_i) begin
      AST_IDLE_ZERO: assert (rd_data_o == '0); // R9
    end
  end

  AST_KEEP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && rd_en_i && (inc_i == dec_i)) ##1
      (rd_en_i && $stable(stk_sel_i) && $stable(byte_hi_i))
      |-> $stable(rd_data_o)); // R11

endmodule

bind dual_stack_unit stk_checker #(
  .PTR_W (PTR_W),
  .BYTE_W(BYTE_W)
) i_stk_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .inc_i      (inc_i),
  .dec_i      (dec_i),
  .stk_sel_i  (stk_sel_i),
  .byte_hi_i  (byte_hi_i),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .pstk_ptr_o (pstk_ptr_o),
  .rstk_ptr_o (rstk_ptr_o)
);

// File: tb/test_dual_stack_unit.sv
`timescale 1ns/1ps
module test_dual_stack_unit;

  logic       clk;
  logic       rst_n;
  logic       inc_i, dec_i, stk_sel_i, byte_hi_i, rd_en_i, wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o, pstk_ptr_o, rstk_ptr_o;

  int n_tests = 0;
  int n_fail  = 0;

  // Behavioural reference: two integer pointers and a sparse byte store.
  int       m_ptr [2];
  bit [7:0] m_mem [int];

  dual_stack_unit i_dual_stack_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (inc_i),
    .dec_i      (dec_i),
    .stk_sel_i  (stk_sel_i),
    .byte_hi_i  (byte_hi_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .pstk_ptr_o (pstk_ptr_o),
    .rstk_ptr_o (rstk_ptr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int m_addr(input bit sel, input bit hi);
    return (int'(sel) << 9) | (m_ptr[sel] << 1) | int'(hi);
  endfunction

  // Drive one cycle away from the edge, compare, then advance the model at the edge.
  task automatic step(input string req, input bit inc, input bit dec, input bit sel,
                      input bit hi, input bit rd, input bit wr, input bit [7:0] wd);
    int a;
    @(negedge clk);
    inc_i = inc; dec_i = dec; stk_sel_i = sel; byte_hi_i = hi;
    rd_en_i = rd; wr_en_i = wr; wr_data_i = wd;
    #1;
    check(req, "param ptr", int'(pstk_ptr_o), m_ptr[0]);
    check(req, "return ptr", int'(rstk_ptr_o), m_ptr[1]);
    a = m_addr(sel, hi);
    if (!rd) check("R9", "idle read", int'(rd_data_o), 0);
    else if (m_mem.exists(a)) check(req, "read byte", int'(rd_data_o), int'(m_mem[a]));
    @(posedge clk);
    if (wr) m_mem[a] = wd;                       // R10: pre-edge pointer
    if (inc && !dec) m_ptr[sel] = (m_ptr[sel] + 1) % 256;
    if (dec && !inc) m_ptr[sel] = (m_ptr[sel] + 255) % 256;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    inc_i = 0; dec_i = 0; stk_sel_i = 0; byte_hi_i = 0;
    rd_en_i = 0; wr_en_i = 0; wr_data_i = '0;
    m_ptr[0] = 0; m_ptr[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "param ptr in reset", int'(pstk_ptr_o), 0);
    check("R1", "return ptr in reset", int'(rstk_ptr_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: increments on each stack
    for (int i = 0; i < 5; i++) step("R2", 1, 0, 0, 0, 0, 0, 8'h00);
    for (int i = 0; i < 3; i++) step("R2", 1, 0, 1, 0, 0, 0, 8'h00);
    // R3: decrements
    step("R3", 0, 1, 0, 0, 0, 0, 8'h00);
    step("R3", 0, 1, 1, 0, 0, 0, 8'h00);
    // R5: both strobes cancel
    step("R5", 1, 1, 0, 0, 0, 0, 8'h00);
    step("R5", 1, 1, 1, 0, 0, 0, 8'h00);
    step("R5", 0, 0, 1, 0, 0, 0, 8'h00);

    // R6/R7: write both bytes of a word, read back
    step("R6", 0, 0, 0, 0, 0, 1, 8'hA5);
    step("R7", 0, 0, 0, 1, 0, 1, 8'h3C);
    step("R6", 0, 0, 0, 0, 1, 0, 8'h00);
    step("R7", 0, 0, 0, 1, 1, 0, 8'h00);
    // R8: drive return pointer equal to param pointer, write, then reread param
    while (m_ptr[1] != m_ptr[0]) step("R8", 1, 0, 1, 0, 0, 0, 8'h00);
    step("R8", 0, 0, 1, 0, 0, 1, 8'h77);
    step("R8", 0, 0, 1, 1, 0, 1, 8'h88);
    step("R8", 0, 0, 0, 0, 1, 0, 8'h00);
    step("R8", 0, 0, 0, 1, 1, 0, 8'h00);
    step("R8", 0, 0, 1, 0, 1, 0, 8'h00);
    // R9: read disabled
    step("R9", 0, 0, 0, 0, 0, 0, 8'h00);
    // R10: push as write+inc in one cycle lands at old top
    step("R10", 1, 0, 0, 0, 1, 1, 8'h5A);
    step("R10", 0, 1, 0, 0, 1, 0, 8'h00);
    step("R10", 0, 0, 0, 0, 1, 0, 8'h00);
    // R11: toggling everything but write enable keeps stored bytes
    step("R11", 0, 0, 0, 1, 1, 0, 8'hFF);
    step("R11", 1, 1, 1, 0, 1, 0, 8'hEE);
    step("R11", 0, 0, 0, 1, 1, 0, 8'h11);

    // R4: wrap down from 0 and up from 255 on the return stack
    while (m_ptr[1] != 0) step("R4", 0, 1, 1, 0, 0, 0, 8'h00);
    step("R4", 0, 1, 1, 0, 0, 0, 8'h00);
    step("R4", 1, 0, 1, 0, 0, 0, 8'h00);
    step("R4", 0, 0, 1, 0, 0, 0, 8'h00);
    // R4: walk param stack up past 255
    while (m_ptr[0] != 255) step("R4", 1, 0, 0, 0, 0, 0, 8'h00);
    step("R4", 1, 0, 0, 0, 0, 0, 8'h00);
    step("R4", 0, 0, 0, 0, 0, 0, 8'h00);

    // Mixed random traffic across all requirements
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] r;
      r = 8'($urandom);
      step("R6", r[0] & r[7], r[1] & ~r[7], r[2], r[3], r[4], r[5] | r[6], 8'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule